// File: doc/BRIEF.md
# Fractional Multiply-Accumulate Data ALU

This block is the arithmetic core of a signed fractional datapath. It holds four 24-bit operand registers, loaded one per cycle from a write bus, and two 56-bit accumulators. Each accumulator is a 48-bit body with 8 guard bits above it. In every cycle one instruction can update one accumulator. The instruction is a multiply, multiply-accumulate, multiply-subtract, add, subtract, bitwise AND/OR/XOR on the upper body word, or a one-bit arithmetic shift. A single multiply-accumulate unit finishes each instruction in one clock, with no pipeline stages.

Two read ports deliver accumulator contents as 24-bit words. Each port can first scale the value up or down by one bit. It then applies a limiter. When the guard bits hold magnitude, the limiter replaces the word with the most positive or most negative 24-bit value and raises a limit flag. Guard bits let long accumulations grow past the body range without wrapping, and the limiter means a read never returns a word whose sign is wrong.

Top module: `frac_mac_alu`

## Requirements
- R1: A synchronous active-high reset clears all four operand registers and both accumulators, so every read returns 0 with the limit flag low.
- R2: With the write enable high, the write data is stored at the clock edge into the operand register named by the write select (0, 1, 2, 3 name the four registers). An instruction issued in the same cycle uses the value held before that write.
- R3: Opcode encoding is 0 idle, 1 multiply, 2 multiply-accumulate, 3 multiply-subtract, 4 add, 5 subtract, 6 AND, 7 OR, 8 XOR, 9 shift left, 10 shift right. Multiply loads the target accumulator with twice the signed product of the two selected operands, computed exactly in 56 bits.
- R4: Multiply-accumulate adds that doubled product to the target accumulator, and multiply-subtract takes it away. Both wrap modulo 2^56.
- R5: Add and subtract take the first selected operand, sign-extended and placed in body bits 47:24, and add it to the target accumulator or take it away from it.
- R6: AND, OR and XOR combine body bits 47:24 with the first selected operand. Bits 55:48 and 23:0 of the target keep their values.
- R7: Shift left moves the whole 56-bit target up one bit and fills a zero at the bottom. Shift right is an arithmetic one-bit shift of the 56-bit target.
- R8: Only the accumulator named by the target select (0 or 1) can change. Idle and opcodes 11 to 15 change neither accumulator.
- R9: A read port's scale code selects the value to read: 0 and 3 leave the accumulator as it is, 1 doubles it (a 56-bit left shift) and 2 halves it (an arithmetic right shift).
- R10: If bits 55:47 of the scaled value are all equal, the port returns bits 47:24 with the flag low. Otherwise it returns 0x7FFFFF when bit 55 is 0 and 0x800000 when bit 55 is 1, with the flag high.
- R11: The two read ports are combinational and independent. Each has its own accumulator select, scale, data and flag, and either port can read either accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 4 | Instruction opcode |
| src_a_i | input | 2 | First operand register select |
| src_b_i | input | 2 | Second operand register select |
| dst_i | input | 1 | Target accumulator select |
| wr_en_i | input | 1 | Operand register write enable |
| wr_sel_i | input | 2 | Operand register written |
| wr_data_i | input | 24 | Operand write data |
| rd_acc_i | input | 2 | Accumulator select, one bit per read port |
| rd_scale_i | input | 4 | Scale code, two bits per read port |
| rd_data_o | output | 48 | Limited read words, port 0 in bits 23:0 |
| rd_lim_o | output | 2 | Limit flag, one bit per read port |

## Verification
The multiply paths are swept over every ordered pair of eight operands: zero, the smallest positive, minus one LSB, one half, the largest positive, minus one, and two mixed patterns. Together these separate sign handling, the product doubling and the single case where minus one times minus one overflows the body. Long runs of add and subtract push the guard bits through both saturation polarities and back, which shows whether the limiter works from the guard bits or from the body alone. Each read uses all three scale codes on both ports with the two ports crossed, and a run of left shifts brings the low body bits up into view after a logic operation.

// File: rtl/frac_mac_pkg.sv
package frac_mac_pkg;

    localparam int DATA_W  = 24;
    localparam int EXT_W   = 8;
    localparam int BODY_W  = 2 * DATA_W;
    localparam int ACC_W   = BODY_W + EXT_W;
    localparam int NUM_IN  = 4;
    localparam int SEL_W   = $clog2(NUM_IN);
    localparam int NUM_ACC = 2;
    localparam int NUM_RD  = 2;
    localparam int SCL_W   = 2;

    typedef logic signed [DATA_W-1:0] word_t;
    typedef logic signed [ACC_W-1:0]  acc_t;

    localparam word_t WORD_MAX = {1'b0, {(DATA_W-1){1'b1}}};
    localparam word_t WORD_MIN = {1'b1, {(DATA_W-1){1'b0}}};

    typedef enum logic [3:0] {
        OP_IDLE = 4'd0,
        OP_MPY  = 4'd1,
        OP_MAC  = 4'd2,
        OP_MSU  = 4'd3,
        OP_ADD  = 4'd4,
        OP_SUB  = 4'd5,
        OP_AND  = 4'd6,
        OP_OR   = 4'd7,
        OP_XOR  = 4'd8,
        OP_SHL  = 4'd9,
        OP_SHR  = 4'd10
    } alu_op_e;

    typedef enum logic [SCL_W-1:0] {
        SCL_KEEP  = 2'd0,
        SCL_UP    = 2'd1,
        SCL_DOWN  = 2'd2,
        SCL_KEEP2 = 2'd3
    } scale_e;

    typedef struct packed {
        alu_op_e          op;
        logic [SEL_W-1:0] src_a;
        logic [SEL_W-1:0] src_b;
        logic             dst;
    } alu_cmd_t;

    // Sign-extended operand aligned to the upper word of the body.
    function automatic acc_t align_word(input word_t w);
        return acc_t'({{EXT_W{w[DATA_W-1]}}, w, {DATA_W{1'b0}}});
    endfunction

endpackage

// File: rtl/frac_mac_regs.sv
module frac_mac_regs
    import frac_mac_pkg::*;
#(
    parameter int N = NUM_IN,
    parameter int W = DATA_W,
    localparam int SW = $clog2(N)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           wr_en,
    input  logic [SW-1:0]  wr_sel,
    input  logic [W-1:0]   wr_data,
    output logic [N*W-1:0] regs_flat
);

    logic [W-1:0] regs_q [N];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < N; k++) regs_q[k] <= '0;
        end else if (wr_en) begin
            regs_q[wr_sel] <= wr_data;
        end
    end

    for (genvar g = 0; g < N; g++) begin : g_flat
        assign regs_flat[g*W +: W] = regs_q[g];
    end

endmodule

// File: rtl/frac_mac_core.sv
module frac_mac_core
    import frac_mac_pkg::*;
(
    input  alu_op_e op,
    input  word_t   opa,
    input  word_t   opb,
    input  acc_t    acc_cur,
    output acc_t    acc_nxt,
    output logic    upd
);

    logic signed [BODY_W-1:0] prod;
    acc_t                     prod_x2;
    acc_t                     word_al;

    assign prod    = opa * opb;
    assign prod_x2 = acc_t'({{EXT_W{prod[BODY_W-1]}}, prod}) <<< 1;
    assign word_al = align_word(opa);

    always_comb begin
        acc_nxt = acc_cur;
        upd     = 1'b1;
        case (op)
            OP_MPY: acc_nxt = prod_x2;
            OP_MAC: acc_nxt = acc_cur + prod_x2;
            OP_MSU: acc_nxt = acc_cur - prod_x2;
            OP_ADD: acc_nxt = acc_cur + word_al;
            OP_SUB: acc_nxt = acc_cur - word_al;
            OP_AND: acc_nxt[BODY_W-1:DATA_W] = acc_cur[BODY_W-1:DATA_W] & opa;
            OP_OR:  acc_nxt[BODY_W-1:DATA_W] = acc_cur[BODY_W-1:DATA_W] | opa;
            OP_XOR: acc_nxt[BODY_W-1:DATA_W] = acc_cur[BODY_W-1:DATA_W] ^ opa;
            OP_SHL: acc_nxt = acc_cur <<< 1;
            OP_SHR: acc_nxt = acc_cur >>> 1;
            default: upd = 1'b0;
        endcase
    end

endmodule

// File: rtl/frac_mac_limiter.sv
module frac_mac_limiter
    import frac_mac_pkg::*;
(
    input  acc_t             acc,
    input  logic [SCL_W-1:0] scale,
    output word_t            data,
    output logic             lim
);

    acc_t           scaled;
    logic [EXT_W:0] guard;
    logic           in_range;

    always_comb begin
        case (scale_e'(scale))
            SCL_UP:   scaled = acc <<< 1;
            SCL_DOWN: scaled = acc >>> 1;
            default:  scaled = acc;
        endcase
    end

    assign guard    = scaled[ACC_W-1:BODY_W-1];
    assign in_range = (&guard) | ~(|guard);
    assign lim      = ~in_range;
    assign data     = in_range ? word_t'(scaled[BODY_W-1:DATA_W])
                    : (scaled[ACC_W-1] ? WORD_MIN : WORD_MAX);

endmodule

// File: rtl/frac_mac_alu.sv
module frac_mac_alu
    import frac_mac_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic [3:0]               op_i,
    input  logic [SEL_W-1:0]         src_a_i,
    input  logic [SEL_W-1:0]         src_b_i,
    input  logic                     dst_i,
    input  logic                     wr_en_i,
    input  logic [SEL_W-1:0]         wr_sel_i,
    input  logic [DATA_W-1:0]        wr_data_i,
    input  logic [NUM_RD-1:0]        rd_acc_i,
    input  logic [SCL_W*NUM_RD-1:0]  rd_scale_i,
    output logic [DATA_W*NUM_RD-1:0] rd_data_o,
    output logic [NUM_RD-1:0]        rd_lim_o
);

    logic [NUM_IN*DATA_W-1:0] regs_flat;
    alu_cmd_t                 cmd;
    word_t                    opa, opb;
    acc_t                     acc_q [NUM_ACC];
    acc_t                     acc_cur, acc_nxt;
    logic                     upd;

    frac_mac_regs #(.N(NUM_IN), .W(DATA_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en_i),
        .wr_sel    (wr_sel_i),
        .wr_data   (wr_data_i),
        .regs_flat (regs_flat)
    );

    assign cmd.op    = alu_op_e'(op_i);
    assign cmd.src_a = src_a_i;
    assign cmd.src_b = src_b_i;
    assign cmd.dst   = dst_i;

    assign opa     = word_t'(regs_flat[cmd.src_a*DATA_W +: DATA_W]);
    assign opb     = word_t'(regs_flat[cmd.src_b*DATA_W +: DATA_W]);
    assign acc_cur = acc_q[cmd.dst];

    frac_mac_core u_core (
        .op      (cmd.op),
        .opa     (opa),
        .opb     (opb),
        .acc_cur (acc_cur),
        .acc_nxt (acc_nxt),
        .upd     (upd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < NUM_ACC; k++) acc_q[k] <= '0;
        end else if (upd) begin
            acc_q[cmd.dst] <= acc_nxt;
        end
    end

    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        word_t rd_word;
        frac_mac_limiter u_lim (
            .acc   (acc_q[rd_acc_i[p]]),
            .scale (rd_scale_i[p*SCL_W +: SCL_W]),
            .data  (rd_word),
            .lim   (rd_lim_o[p])
        );
        assign rd_data_o[p*DATA_W +: DATA_W] = rd_word;
    end

endmodule

// File: rtl/frac_mac_alu_chk.sv
module frac_mac_alu_chk
    import frac_mac_pkg::*;
(
    input logic                     clk,
    input logic                     rst,
    input logic [3:0]               op,
    input logic                     dst,
    input logic                     wr_en,
    input logic [NUM_IN*DATA_W-1:0] regs_flat,
    input acc_t                     acc0,
    input acc_t                     acc1,
    input logic [DATA_W*NUM_RD-1:0] rd_data,
    input logic [NUM_RD-1:0]        rd_lim
);

    logic is_idle, is_logic;
    assign is_idle  = (op == 4'd0) || (op > 4'd10);
    assign is_logic = (op == 4'd6) || (op == 4'd7) || (op == 4'd8);

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (acc0 == '0) && (acc1 == '0) && (regs_flat == '0));

    assert_regs_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(regs_flat));

    assert_logic_keeps_R6: assert property (@(posedge clk) disable iff (rst)
        (is_logic && !dst) |=> $stable(acc0[DATA_W-1:0]) && $stable(acc0[ACC_W-1:BODY_W]));

    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
        is_idle |=> $stable(acc0) && $stable(acc1));

    assert_other_acc0_R8: assert property (@(posedge clk) disable iff (rst)
        dst |=> $stable(acc0));

    assert_other_acc1_R8: assert property (@(posedge clk) disable iff (rst)
        !dst |=> $stable(acc1));

    assert_sat_word0_R10: assert property (@(posedge clk) disable iff (rst)
        rd_lim[0] |-> (rd_data[DATA_W-1:0] == WORD_MAX) || (rd_data[DATA_W-1:0] == WORD_MIN));

    assert_sat_word1_R10: assert property (@(posedge clk) disable iff (rst)
        rd_lim[1] |-> (rd_data[2*DATA_W-1:DATA_W] == WORD_MAX) || (rd_data[2*DATA_W-1:DATA_W] == WORD_MIN));

endmodule

bind frac_mac_alu frac_mac_alu_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .op        (op_i),
    .dst       (dst_i),
    .wr_en     (wr_en_i),
    .regs_flat (regs_flat),
    .acc0      (acc_q[0]),
    .acc1      (acc_q[1]),
    .rd_data   (rd_data_o),
    .rd_lim    (rd_lim_o)
);

// File: tb/frac_mac_alu_tb.sv
module frac_mac_alu_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  op_i = '0;
    logic [1:0]  src_a_i = '0, src_b_i = '0, wr_sel_i = '0;
    logic        dst_i = 1'b0, wr_en_i = 1'b0;
    logic [23:0] wr_data_i = '0;
    logic [1:0]  rd_acc_i = '0;
    logic [3:0]  rd_scale_i = '0;
    logic [47:0] rd_data_o;
    logic [1:0]  rd_lim_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic signed [55:0] m_acc [2];
    logic signed [23:0] m_reg [4];

    localparam logic signed [23:0] VALS [8] = '{
        24'sh000000, 24'sh000001, 24'shFFFFFF, 24'sh400000,
        24'sh7FFFFF, 24'sh800000, 24'sh123456, 24'shEDCBAA};

    always #(CLK_PERIOD/2) clk = ~clk;

    frac_mac_alu u_dut (
        .clk (clk), .rst (rst), .op_i (op_i), .src_a_i (src_a_i), .src_b_i (src_b_i),
        .dst_i (dst_i), .wr_en_i (wr_en_i), .wr_sel_i (wr_sel_i), .wr_data_i (wr_data_i),
        .rd_acc_i (rd_acc_i), .rd_scale_i (rd_scale_i), .rd_data_o (rd_data_o),
        .rd_lim_o (rd_lim_o)
    );

    function automatic longint floor_div(input longint v, input longint d);
        longint r;
        r = v % d;
        if (r < 0) r = r + d;
        return (v - r) / d;
    endfunction

    // Expected read word and flag from the requirements (R9, R10).
    function automatic void exp_read(input logic signed [55:0] a, input int sc,
                                     output logic [23:0] d, output logic l);
        logic signed [55:0] s;
        longint v;
        case (sc)
            1: s = 56'(longint'(a) * 2);
            2: s = 56'(floor_div(longint'(a), 2));
            default: s = a;
        endcase
        v = longint'(s);
        if (v > 64'sd140737488355327) begin d = 24'h7FFFFF; l = 1'b1; end
        else if (v < -64'sd140737488355328) begin d = 24'h800000; l = 1'b1; end
        else begin d = 24'(floor_div(v, 64'sd16777216)); l = 1'b0; end
    endfunction

    function automatic logic signed [55:0] model_next(input int op, input logic signed [55:0] a,
                                                      input logic signed [23:0] x, input logic signed [23:0] y);
        longint p, w, av;
        logic signed [55:0] r;
        p  = longint'(x) * longint'(y) * 2;
        w  = longint'(x) * 64'sd16777216;
        av = longint'(a);
        r  = a;
        case (op)
            1:  r = 56'(p);
            2:  r = 56'(av + p);
            3:  r = 56'(av - p);
            4:  r = 56'(av + w);
            5:  r = 56'(av - w);
            6:  r[47:24] = a[47:24] & x;
            7:  r[47:24] = a[47:24] | x;
            8:  r[47:24] = a[47:24] ^ x;
            9:  r = 56'(av * 2);
            10: r = 56'(floor_div(av, 2));
            default: r = a;
        endcase
        return r;
    endfunction

    task automatic check(input string req, input logic [24:0] act, input logic [24:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // Both ports, both accumulators, all scales, ports crossed (R9 R10 R11).
    task automatic check_reads(input string tag);
        logic [23:0] d0, d1;
        logic        l0, l1;
        for (int a = 0; a < 2; a++) begin
            for (int sc = 0; sc < 3; sc++) begin
                rd_acc_i   = {a[0] ^ 1'b1, a[0]};
                rd_scale_i = {2'((sc + 1) % 3), 2'(sc)};
                #1;
                exp_read(m_acc[a], sc, d0, l0);
                exp_read(m_acc[1-a], (sc + 1) % 3, d1, l1);
                check({tag, " port0 R9 R10"}, {rd_lim_o[0], rd_data_o[23:0]}, {l0, d0});
                check({tag, " port1 R11"}, {rd_lim_o[1], rd_data_o[47:24]}, {l1, d1});
            end
        end
    endtask

    task automatic run_op(input string tag, input int op, input int sa, input int sb, input int dst,
                          input bit we, input int wsel, input logic [23:0] wdata);
        @(negedge clk);
        op_i = 4'(op); src_a_i = 2'(sa); src_b_i = 2'(sb); dst_i = dst[0];
        wr_en_i = we; wr_sel_i = 2'(wsel); wr_data_i = wdata;
        @(posedge clk);
        m_acc[dst] = model_next(op, m_acc[dst], m_reg[sa], m_reg[sb]);
        if (we) m_reg[wsel] = wdata;
        @(negedge clk);
        op_i = '0; wr_en_i = 1'b0;
        check_reads(tag);
    endtask

    task automatic write_reg(input string tag, input int sel, input logic [23:0] val);
        run_op(tag, 0, 0, 0, 0, 1'b1, sel, val);
    endtask

    task automatic model_reset();
        for (int k = 0; k < 2; k++) m_acc[k] = '0;
        for (int k = 0; k < 4; k++) m_reg[k] = '0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check_reads("R1 reset state");

        // Multiply family over all operand pairs (R2 R3 R4 R5 R8).
        for (int i = 0; i < 8; i++) begin
            for (int j = 0; j < 8; j++) begin
                write_reg("R2 write X", 0, VALS[i]);
                write_reg("R2 write Y", 2, VALS[j]);
                run_op("R3 multiply", 1, 0, 2, 0, 1'b0, 0, '0);
                run_op("R4 accumulate", 2, 0, 2, 1, 1'b0, 0, '0);
                if ((i + j) % 3 == 0) run_op("R4 subtract product", 3, 2, 0, 1, 1'b0, 0, '0);
                if (j == 7) run_op("R5 add word", 4, 0, 0, 0, 1'b0, 0, '0);
            end
        end

        // Guard bits filled both ways (R5 R10).
        write_reg("R2 write", 1, 24'h7FFFFF);
        for (int k = 0; k < 200; k++) run_op("R5 add into guard R10", 4, 1, 0, 1, 1'b0, 0, '0);
        for (int k = 0; k < 400; k++) run_op("R5 subtract into guard R10", 5, 1, 0, 1, 1'b0, 0, '0);

        // Logic operations on the upper word (R6).
        for (int i = 0; i < 8; i++) begin
            write_reg("R2 write", 1, VALS[i]);
            run_op("R6 or", 7, 1, 0, 0, 1'b0, 0, '0);
            run_op("R6 and", 6, 1, 0, 1, 1'b0, 0, '0);
            run_op("R6 xor", 8, 1, 0, 0, 1'b0, 0, '0);
        end

        // Low body bits survive a logic op, then are shifted into view (R6 R7).
        write_reg("R2 write", 0, 24'h123457);
        write_reg("R2 write", 2, 24'h000003);
        run_op("R3 small product", 1, 0, 2, 0, 1'b0, 0, '0);
        write_reg("R2 write", 1, 24'h000000);
        run_op("R6 clear upper", 6, 1, 0, 0, 1'b0, 0, '0);
        for (int k = 0; k < 23; k++) run_op("R6 R7 shift up low bits", 9, 0, 0, 0, 1'b0, 0, '0);
        for (int k = 0; k < 30; k++) run_op("R7 shift right", 10, 0, 0, 0, 1'b0, 0, '0);
        write_reg("R2 write", 0, 24'h800000);
        run_op("R3 negative product", 1, 0, 2, 1, 1'b0, 0, '0);
        for (int k = 0; k < 30; k++) run_op("R7 shift left", 9, 0, 0, 1, 1'b0, 0, '0);
        for (int k = 0; k < 40; k++) run_op("R7 shift right negative", 10, 0, 0, 1, 1'b0, 0, '0);

        // Write and use in the same cycle (R2).
        write_reg("R2 write", 0, 24'h200000);
        write_reg("R2 write", 2, 24'h300000);
        run_op("R2 same cycle old value", 1, 0, 2, 0, 1'b1, 0, 24'h7FFFFF);
        run_op("R2 new value seen", 1, 0, 2, 1, 1'b0, 0, '0);

        // Unused opcodes change nothing (R8).
        for (int c = 11; c < 16; c++) run_op("R8 unused opcode", c, 0, 2, c % 2, 1'b0, 0, '0);
        run_op("R8 idle", 0, 0, 2, 0, 1'b0, 0, '0);

        // Reset in mid-run (R1).
        @(negedge clk);
        rst = 1'b1; op_i = 4'd2;
        @(posedge clk);
        model_reset();
        @(negedge clk);
        rst = 1'b0; op_i = '0;
        check_reads("R1 reset mid-run");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule